// File: doc/BRIEF.md
# Bypass-Mode Flash Block Programmer

This controller sits on the host side of a parallel flash device and writes a run of consecutive words into it. Software or an upstream engine gives it a start pulse, a first word address and a word count. The data words then arrive one at a time over a valid/ready stream. The controller puts the device into its fast-programming (unlock-bypass) mode once. For each word it issues a two-write program command and polls the device until the write finishes. It then reads the location back to confirm the stored value. When all words are done it takes the device out of bypass mode.

Completion polling uses the toggle-free status convention. While the internal write is running, bit 7 of a read returns the complement of the written bit 7, and bit 5 rises when the device gives up. A status timeout or a read-back mismatch stops the transfer. The failing address is recorded and the error flag is set. The bypass exit sequence is still issued before the done pulse. Every bus write holds its strobe for a parameterised number of clocks. Address and data are set up one clock before the strobe and held one clock after it.

Top module: `flash_bypass_prog`

## Requirements
- R1: After an accepted start, the first three bus writes are (UNL_A, 00AAh), (UNL_B, 0055h), (UNL_A, 0020h), where UNL_A defaults to 00555h and UNL_B to 002AAh.
- R2: Each word k of the transfer is written as (UNL_A, 00A0h) followed by (start address + k, word k), with addresses wrapping modulo 2^AW.
- R3: The write strobe fl_wr stays high for exactly WE_CYC consecutive clocks. fl_addr and fl_wdata hold their values from one clock before the strobe rises until one clock after it falls.
- R4: After a word's data write, the controller reads that word's address until read bit 7 equals bit 7 of the written word. It then makes one verify read of the same address. The next word's command starts only after the verify read returns the full written word. fl_wr and fl_rd are never high together.
- R5: If a status read has bit 7 wrong and bit 5 high, exactly one more status read follows. If bit 7 is still wrong on that read, the transfer stops: error is set and err_addr is set to the word's address.
- R6: If the verify read differs from the written word, the transfer stops with error set and err_addr set to that word's address. No further word is requested or written.
- R7: Every transfer ends with the writes (UNL_A, 0090h) then (UNL_A, 0000h), including one stopped by R5 or R6.
- R8: done is a single-cycle pulse that comes only after the last exit write has completed. busy is low while done is high. Out of reset, busy, done, error, in_ready, fl_wr and fl_rd are all low.
- R9: A word count of zero produces only the three entry writes and the two exit writes, then done with error low.
- R10: A start pulse while busy is high has no effect on the bus sequence or on the result.
- R11: in_ready is high only while the controller waits for the next word. Exactly one stream word is taken per programmed word, including the failing one.
- R12: error and err_addr keep their values after done until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| start_addr | input | AW | Address of the first word |
| word_count | input | NW | Number of words to program |
| in_valid | input | 1 | Stream word available |
| in_data | input | DW | Stream word |
| in_ready | output | 1 | Controller takes the stream word this cycle |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_wr | output | 1 | Write strobe, active high |
| fl_rd | output | 1 | Read strobe; device answers on fl_rdata in the next cycle |
| fl_rdata | input | DW | Flash bus read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Transfer stopped on a status timeout or verify mismatch |
| err_addr | output | AW | Address of the word that failed |

## Verification
The bench models the device behaviourally. It holds its own memory and a busy-read budget per word, and it can raise the timeout bit on a chosen poll. Against this model it checks every bus write and the number of reads spent on each word. The corner cases it targets are these:
- A poll where bit 5 is raised but bit 7 then recovers. A design that aborts on bit 5 alone would report a false error.
- A hard timeout. A design that skips the re-read, or that forgets the exit writes after an error, would leave the write queue unmatched.
- A stored value that passes polling but fails verify. A design that trusts the poll would advance.
- A zero word count, address wrap, a stalled input stream, and a stray start while busy, which a careless design would restart on.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;

  typedef enum logic [3:0] {
    H_IDLE, H_ENTRY, H_FETCH, H_PCMD, H_PDATA,
    H_POLL, H_RECHK, H_VERIFY, H_EXIT, H_FIN
  } host_st_t;

  localparam logic [7:0] C_KEY1      = 8'hAA;
  localparam logic [7:0] C_KEY2      = 8'h55;
  localparam logic [7:0] C_BYP_ENTER = 8'h20;
  localparam logic [7:0] C_BYP_PROG  = 8'hA0;
  localparam logic [7:0] C_BYP_RST1  = 8'h90;
  localparam logic [7:0] C_BYP_RST2  = 8'h00;

  // data byte of the n-th bypass entry write
  function automatic logic [7:0] entry_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return C_KEY1;
      2'd1:    return C_KEY2;
      default: return C_BYP_ENTER;
    endcase
  endfunction

  // data byte of the n-th bypass exit write
  function automatic logic [7:0] exit_byte(input logic idx);
    return idx ? C_BYP_RST2 : C_BYP_RST1;
  endfunction

  // status bit 7 carries the true data bit once the write has finished
  function automatic logic status_settled(input logic [7:0] rd_lo, input logic [7:0] wr_lo);
    return rd_lo[7] == wr_lo[7];
  endfunction

  // status bit 5 flags an internal time limit
  function automatic logic status_limit(input logic [7:0] rd_lo);
    return rd_lo[5];
  endfunction

endpackage

// File: rtl/fbp_bus_engine.sv
`timescale 1ns/1ps
module fbp_bus_engine #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int WE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_go,
  input  logic          op_rd,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  output logic          op_done,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wr,
  output logic          bus_rd
);
  localparam int CW = (WE_CYC > 1) ? $clog2(WE_CYC) : 1;

  typedef enum logic [2:0] {E_IDLE, E_SET, E_STB, E_HLD, E_RDQ, E_RDC} eng_st_t;

  eng_st_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cnt       <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (st)
        E_IDLE: if (op_go) begin
          bus_addr <= op_addr;
          if (!op_rd) bus_wdata <= op_data;
          st <= op_rd ? E_RDQ : E_SET;
        end
        E_SET: begin
          cnt <= '0;
          st  <= E_STB;
        end
        E_STB: begin
          if (cnt == CW'(WE_CYC - 1)) st <= E_HLD;
          else                        cnt <= cnt + CW'(1);
        end
        E_HLD:   st <= E_IDLE;
        E_RDQ:   st <= E_RDC;
        E_RDC:   st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign bus_wr  = (st == E_STB);
  assign bus_rd  = (st == E_RDQ);
  assign op_done = (st == E_HLD) || (st == E_RDC);

endmodule

// File: rtl/fbp_poll_judge.sv
`timescale 1ns/1ps
module fbp_poll_judge import fbp_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_word,
  input  logic [DW-1:0] wr_word,
  output logic          settled,
  output logic          limit,
  output logic          same
);
  assign settled = status_settled(rd_word[7:0], wr_word[7:0]);
  assign limit   = status_limit(rd_word[7:0]);
  assign same    = (rd_word == wr_word);
endmodule

// File: rtl/flash_bypass_prog.sv
`timescale 1ns/1ps
module flash_bypass_prog import fbp_pkg::*; #(
  parameter int            AW     = 20,
  parameter int            DW     = 16,
  parameter int            NW     = 16,
  parameter int            WE_CYC = 3,
  parameter logic [AW-1:0] UNL_A  = 'h555,
  parameter logic [AW-1:0] UNL_B  = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [NW-1:0] word_count,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_wr,
  output logic          fl_rd,
  input  logic [DW-1:0] fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr
);
  host_st_t      st;
  logic [1:0]    step;
  logic [AW-1:0] cur_addr;
  logic [NW-1:0] remain;
  logic [DW-1:0] word_q;
  logic          err_q;
  logic [AW-1:0] err_addr_q;

  logic          op_go, op_rd, op_done;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          st_settled, st_limit, rb_same;

  // named events for the checker
  logic          word_ok_ev;
  logic          abort_ev;

  fbp_bus_engine #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .op_go(op_go), .op_rd(op_rd), .op_addr(op_addr), .op_data(op_data),
    .op_done(op_done),
    .bus_addr(fl_addr), .bus_wdata(fl_wdata), .bus_wr(fl_wr), .bus_rd(fl_rd)
  );

  fbp_poll_judge #(.DW(DW)) judge_i (
    .rd_word(fl_rdata), .wr_word(word_q),
    .settled(st_settled), .limit(st_limit), .same(rb_same)
  );

  always_comb begin
    op_go   = 1'b0;
    op_rd   = 1'b0;
    op_addr = UNL_A;
    op_data = '0;
    case (st)
      H_ENTRY: begin
        op_go   = 1'b1;
        op_addr = (step == 2'd1) ? UNL_B : UNL_A;
        op_data = DW'(entry_byte(step));
      end
      H_PCMD: begin
        op_go   = 1'b1;
        op_data = DW'(C_BYP_PROG);
      end
      H_PDATA: begin
        op_go   = 1'b1;
        op_addr = cur_addr;
        op_data = word_q;
      end
      H_POLL, H_RECHK, H_VERIFY: begin
        op_go   = 1'b1;
        op_rd   = 1'b1;
        op_addr = cur_addr;
      end
      H_EXIT: begin
        op_go   = 1'b1;
        op_data = DW'(exit_byte(step[0]));
      end
      default: ;
    endcase
  end

  assign word_ok_ev = (st == H_VERIFY) && op_done && rb_same;
  assign abort_ev   = op_done && (((st == H_VERIFY) && !rb_same) ||
                                  ((st == H_RECHK)  && !st_settled));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= H_IDLE;
      step       <= '0;
      cur_addr   <= '0;
      remain     <= '0;
      word_q     <= '0;
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else begin
      case (st)
        H_IDLE: if (start) begin
          cur_addr   <= start_addr;
          remain     <= word_count;
          err_q      <= 1'b0;
          err_addr_q <= '0;
          step       <= '0;
          st         <= H_ENTRY;
        end
        H_ENTRY: if (op_done) begin
          if (step == 2'd2) begin
            step <= '0;
            st   <= (remain == '0) ? H_EXIT : H_FETCH;
          end else begin
            step <= step + 2'd1;
          end
        end
        H_FETCH: if (in_valid) begin
          word_q <= in_data;
          st     <= H_PCMD;
        end
        H_PCMD:  if (op_done) st <= H_PDATA;
        H_PDATA: if (op_done) st <= H_POLL;
        H_POLL: if (op_done) begin
          if (st_settled)    st <= H_VERIFY;
          else if (st_limit) st <= H_RECHK;
        end
        H_RECHK: if (op_done) begin
          if (st_settled) st <= H_VERIFY;
          else begin
            err_q      <= 1'b1;
            err_addr_q <= cur_addr;
            step       <= '0;
            st         <= H_EXIT;
          end
        end
        H_VERIFY: if (op_done) begin
          step <= '0;
          if (rb_same) begin
            cur_addr <= cur_addr + AW'(1);
            remain   <= remain - NW'(1);
            st       <= (remain == NW'(1)) ? H_EXIT : H_FETCH;
          end else begin
            err_q      <= 1'b1;
            err_addr_q <= cur_addr;
            st         <= H_EXIT;
          end
        end
        H_EXIT: if (op_done) begin
          if (step[0]) st <= H_FIN;
          else         step <= 2'd1;
        end
        H_FIN:   st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

  assign in_ready = (st == H_FETCH);
  assign busy     = (st != H_IDLE) && (st != H_FIN);
  assign done     = (st == H_FIN);
  assign error    = err_q;
  assign err_addr = err_addr_q;

endmodule

// File: rtl/fbp_host_sva.sv
`timescale 1ns/1ps
module fbp_host_sva #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int WE_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          in_ready,
  input logic          fl_wr,
  input logic          fl_rd,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic          word_ok_ev,
  input logic          abort_ev
);
  logic [15:0] wr_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_len <= '0;
    else if (fl_wr) wr_len <= wr_len + 16'd1;
    else            wr_len <= '0;
  end

  p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_wr && wr_len != 16'd0) |-> (wr_len == 16'(WE_CYC)));

  p_strobe_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> (wr_len < 16'(WE_CYC)));

  p_bus_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr && $past(fl_wr)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr && fl_rd));

  p_word_ok_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok_ev |-> !error);

  p_abort_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> error);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fl_wr && !fl_rd));

  p_stray_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_ready_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !fl_wr && !fl_rd));

  p_err_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(error));

endmodule

bind flash_bypass_prog fbp_host_sva #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC)) sva_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .error(error), .in_ready(in_ready), .fl_wr(fl_wr), .fl_rd(fl_rd),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .word_ok_ev(word_ok_ev), .abort_ev(abort_ev)
);

// File: tb/flash_bypass_prog_tb_top.sv
`timescale 1ns/1ps
module flash_bypass_prog_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NW = 16;
  localparam int WE = 3;
  localparam logic [AW-1:0] UA = 20'h00555;
  localparam logic [AW-1:0] UB = 20'h002AA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [NW-1:0] word_count = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic          fl_wr, fl_rd;
  logic [DW-1:0] fl_rdata = '0;
  logic          busy, done, error;
  logic [AW-1:0] err_addr;

  flash_bypass_prog #(.AW(AW), .DW(DW), .NW(NW), .WE_CYC(WE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_rdata(fl_rdata), .busy(busy),
    .done(done), .error(error), .err_addr(err_addr)
  );

  always #5 clk = ~clk;

  int vecs = 0;
  int bad  = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // expected bus writes and reads per word
  logic [AW-1:0] q_wa[$];
  logic [DW-1:0] q_wd[$];
  int            q_rd[$];

  // behavioural device
  logic [DW-1:0] mem[int];
  int            cfg_busy[8];
  int            cfg_mode[8];   // 0 plain, 1 limit bit then recovers, 2 hard limit, 3 stored wrong
  int            dev_widx, busy_left, dev_mode, rd_cnt, wcnt;
  logic [AW-1:0] dev_addr = '0;
  bit            arm, word_act, wr_prev;
  logic [AW-1:0] h_addr = '0, prev_addr = '0;
  logic [DW-1:0] h_data = '0, prev_data = '0;

  // stream feeder
  logic [DW-1:0] wd[8];
  int            feed_n, feed_idx, stall_n, gapc, hs_cnt;
  bit            took_q, feed_rst;

  always @(negedge clk) begin
    if (feed_rst) begin
      in_valid = 1'b0; took_q = 1'b0; feed_idx = 0; gapc = stall_n; feed_rst = 1'b0;
    end else if (rst_n) begin
      if (took_q) begin
        feed_idx++; in_valid = 1'b0; gapc = stall_n; took_q = 1'b0;
      end else if (!in_valid && feed_idx < feed_n) begin
        if (gapc > 0) gapc--;
        else begin in_data = wd[feed_idx]; in_valid = 1'b1; end
      end
      if (in_valid && in_ready) begin took_q = 1'b1; hs_cnt++; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_wr && !wr_prev) begin
        chk(prev_addr == fl_addr && prev_data == fl_wdata, "R3 setup before strobe",
            32'(prev_addr), 32'(fl_addr));
        if (q_wa.size() == 0) chk(1'b0, "R1/R2/R7 unexpected write", 32'(fl_wdata), 32'hFFFF);
        else begin
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          ea = q_wa.pop_front();
          ed = q_wd.pop_front();
          chk(fl_addr == ea, "R1/R2/R7 write address", 32'(fl_addr), 32'(ea));
          chk(fl_wdata == ed, "R1/R2/R7 write data", 32'(fl_wdata), 32'(ed));
        end
        if (arm) begin
          mem[int'(fl_addr)] = (cfg_mode[dev_widx] == 3) ? (fl_wdata ^ 16'h0001) : fl_wdata;
          busy_left = cfg_busy[dev_widx];
          dev_mode  = cfg_mode[dev_widx];
          dev_addr  = fl_addr;
          dev_widx++;
          arm = 1'b0; word_act = 1'b1; rd_cnt = 0;
        end else begin
          if (word_act) begin
            int er;
            er = (q_rd.size() > 0) ? q_rd.pop_front() : -1;
            chk(rd_cnt == er, "R4 reads spent on word", 32'(rd_cnt), 32'(er));
            word_act = 1'b0;
          end
          if (fl_wdata == 16'h00A0) arm = 1'b1;
        end
        h_addr = fl_addr; h_data = fl_wdata;
      end
      if (fl_wr) begin
        wcnt++;
        if (wr_prev)
          chk(fl_addr == h_addr && fl_wdata == h_data, "R3 bus held in strobe", 32'(fl_addr), 32'(h_addr));
      end else if (wr_prev) begin
        chk(wcnt == WE, "R3 strobe width", 32'(wcnt), 32'(WE));
        chk(fl_addr == h_addr && fl_wdata == h_data, "R3 hold after strobe", 32'(fl_addr), 32'(h_addr));
        wcnt = 0;
      end
      if (fl_rd) begin
        logic [DW-1:0] r;
        rd_cnt++;
        chk(fl_addr == dev_addr, "R4 read address", 32'(fl_addr), 32'(dev_addr));
        r = mem.exists(int'(dev_addr)) ? mem[int'(dev_addr)] : '1;
        if (dev_mode == 2) begin
          r[7] = ~r[7]; r[5] = 1'b1;
        end else if (busy_left > 0) begin
          r[7] = ~r[7]; r[5] = (dev_mode == 1 && busy_left == 1); busy_left--;
        end
        fl_rdata = r;
      end
      if (done) chk(q_wa.size() == 0, "R8 done only after exit writes", 32'(q_wa.size()), 32'd0);
      wr_prev = fl_wr; prev_addr = fl_addr; prev_data = fl_wdata;
    end
  end

  task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d);
    q_wa.push_back(a); q_wd.push_back(DW'(d));
  endtask

  task automatic run(input logic [AW-1:0] a, input int n, input int stall, input bit poke, input string tag);
    int fail_at = -1;
    int used;
    bit seen = 1'b0;
    q_wa.delete(); q_wd.delete(); q_rd.delete();
    push_w(UA, 8'hAA); push_w(UB, 8'h55); push_w(UA, 8'h20);
    for (int i = 0; i < n; i++) begin
      push_w(UA, 8'hA0);
      q_wa.push_back(a + AW'(i)); q_wd.push_back(wd[i]);
      q_rd.push_back(cfg_mode[i] == 2 ? 2 : cfg_busy[i] + 2);
      if (cfg_mode[i] >= 2) begin fail_at = i; break; end
    end
    push_w(UA, 8'h90); push_w(UA, 8'h00);
    used = (fail_at >= 0) ? fail_at + 1 : n;
    dev_widx = 0; arm = 1'b0; word_act = 1'b0; dev_mode = 0; busy_left = 0;
    feed_n = n; stall_n = stall; hs_cnt = 0; feed_rst = 1'b1;
    @(negedge clk); @(negedge clk);
    start_addr = a; word_count = NW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (25) @(negedge clk);
      chk(busy, "R10 busy before stray start", 32'(busy), 32'd1);
      start_addr = a + AW'(100); word_count = NW'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 20000 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {tag, " R8 done reached"}, 32'(seen), 32'd1);
    chk(error == (fail_at >= 0), {tag, " R5/R6 error flag"}, 32'(error), 32'(fail_at >= 0));
    if (fail_at >= 0)
      chk(err_addr == a + AW'(fail_at), {tag, " R5/R6 err_addr"}, 32'(err_addr), 32'(a + AW'(fail_at)));
    chk(hs_cnt == used, {tag, " R11 words taken"}, 32'(hs_cnt), 32'(used));
    chk(q_wa.size() == 0 && q_rd.size() == 0, {tag, " R7 all writes issued"}, 32'(q_wa.size()), 32'd0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 done lasts one cycle"}, 32'({done, busy}), 32'd0);
    repeat (3) @(negedge clk);
    chk(error == (fail_at >= 0), {tag, " R12 error kept after done"}, 32'(error), 32'(fail_at >= 0));
    chk(!in_ready, {tag, " R11 ready low when idle"}, 32'(in_ready), 32'd0);
  endtask

  task automatic set_cfg(input int i, input logic [DW-1:0] d, input int b, input int m);
    wd[i] = d; cfg_busy[i] = b; cfg_mode[i] = m;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) set_cfg(i, '0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !in_ready && !fl_wr && !fl_rd, "R8 reset state",
        32'({busy, done, error, in_ready, fl_wr, fl_rd}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // plain run with varied completion delay (R1 R2 R3 R4 R7)
    set_cfg(0, 16'h1234, 0, 0); set_cfg(1, 16'h00F0, 1, 0);
    set_cfg(2, 16'hA5A5, 3, 0); set_cfg(3, 16'h7F80, 2, 0);
    run(20'h00100, 4, 0, 1'b0, "plain");
    // zero count (R9)
    run(20'h00200, 0, 0, 1'b0, "R9 empty");
    // wrap, stalled stream, limit bit that recovers, stray start (R5 R10 R11)
    set_cfg(0, 16'hFFFF, 1, 0); set_cfg(1, 16'h0080, 2, 1); set_cfg(2, 16'h5A00, 0, 0);
    run(20'hFFFFE, 3, 3, 1'b1, "R5 recover R10 stray");
    // hard limit on word 1 (R5)
    set_cfg(0, 16'h0101, 1, 0); set_cfg(1, 16'h8888, 0, 2); set_cfg(2, 16'h3333, 0, 0);
    run(20'h04000, 3, 0, 1'b0, "R5 hard limit");
    // stored value wrong on word 2 (R6)
    set_cfg(0, 16'hC3C3, 0, 0); set_cfg(1, 16'h0F0F, 2, 0); set_cfg(2, 16'hBEEF, 0, 3);
    set_cfg(3, 16'h1111, 0, 0);
    run(20'h08000, 4, 1, 1'b0, "R6 verify miss");
    // next start clears the error (R12)
    set_cfg(0, 16'h2468, 1, 0); set_cfg(1, 16'h1357, 0, 0);
    run(20'h0A000, 2, 0, 1'b0, "R12 clear");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule